// File: doc/BRIEF.md
# Boot Remap and Alias Address Decoder

This block decodes the code and SRAM part of an AHB-Lite address space into one-hot slave selects. It also hands each selected slave an address from which the window base has been removed. The decode is purely combinational, so the selects and the local address follow `haddr` in the same cycle. No wait state is added, including when consecutive transfers move between slaves.

Two configuration bits change the map while the system runs. The remap bit places the first 4 MB of the second external SSRAM over the bottom of the flash window. This lets code run from RAM at address zero, while the rest of flash stays visible above that 4 MB. The alias bit makes flash visible a second time in a window higher up.

The two bits live in a small configuration register that is written through a simple write port. Only the power-on reset clears that register, so a system or debug reset leaves the chosen map in place. Addresses that fall in no window go to a built-in default slave. That slave answers real transfers with the two-cycle AHB ERROR response and answers idle or busy cycles with OKAY.

Top module: `boot_map_decoder`

## Requirements
- R1: After power-on reset the configuration reads back 0x2 (alias bit 1 set, remap bit 0 clear). Address 0x0000_0000 and address 0x1800_0000 both select flash.
- R2: With remap clear, addresses 0x0000_0000 to 0x03FF_FFFF select flash (`hsel[0]`), and `slaveAddr` equals `haddr`.
- R3: With remap set, addresses 0x0000_0000 to 0x003F_FFFF select SSRAM1 (`hsel[1]`) with `slaveAddr` equal to `haddr`. Addresses 0x0040_0000 to 0x03FF_FFFF still select flash with `slaveAddr` equal to `haddr`.
- R4: Addresses 0x1000_0000 to 0x103F_FFFF select SSRAM1 whatever the configuration bits hold, with `slaveAddr` equal to `haddr` minus 0x1000_0000.
- R5: With alias set, addresses 0x1800_0000 to 0x1BFF_FFFF select flash with `slaveAddr` equal to `haddr` minus 0x1800_0000. With alias clear, the same range selects the default slave.
- R6: Addresses 0x1EFF_0000 to 0x1EFF_FFFF select the internal RAM (`hsel[2]`) with offset from 0x1EFF_0000. Addresses 0x2000_0000 to 0x203F_FFFF select SSRAM0 (`hsel[3]`) with offset from 0x2000_0000.
- R7: Any other address selects the default slave (`hsel[4]`), and `slaveAddr` equals `haddr`.
- R8: Exactly one bit of `hsel` is high at all times, and it reflects `haddr` in the same cycle with no register in between.
- R9: A write with `cfgWrEn` high stores data bit 1 as alias and data bit 0 as remap. `cfgRdData` shows the stored bits in the next cycle, and its upper bits always read 0 whatever was written there.
- R10: Holding `sysRstN` low leaves the configuration unchanged. Only `porRstN` low returns it to 0x2.
- R11: A NONSEQ or SEQ transfer (`htrans` 2 or 3) accepted with `hreadyIn` high while the default slave is selected produces two cycles of response. The first has `defReadyOut` 0 and `defResp` 1; the second has `defReadyOut` 1 and `defResp` 1.
- R12: IDLE or BUSY cycles to the default slave, and any transfer to a mapped slave, leave the default slave at `defReadyOut` 1 and `defResp` 0.
- R13: Either reset low returns the default slave at once to `defReadyOut` 1 and `defResp` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porRstN | input | 1 | Power-on reset, active low; clears the configuration and the default slave |
| sysRstN | input | 1 | System or debug reset, active low; clears only the default slave |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type (0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ) |
| hreadyIn | input | 1 | Bus ready seen by all slaves; an address phase is taken when high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | DATA_W | Configuration write data; bit 1 alias, bit 0 remap |
| cfgRdData | output | DATA_W | Stored configuration, upper bits zero |
| hsel | output | 5 | One-hot select: 0 flash, 1 SSRAM1, 2 internal RAM, 3 SSRAM0, 4 default |
| slaveAddr | output | ADDR_W | Address local to the selected slave |
| defReadyOut | output | 1 | Default slave ready |
| defResp | output | 1 | Default slave response, 1 means ERROR |

## Verification
The bench builds the decoder with its default parameters: a 32-bit address, a 64 MB flash window, 4 MB SSRAM windows and a 64 KB internal RAM. With these values the 4 MB remap window is only a sixteenth of the flash window, so random offsets drawn across the whole flash window land on both sides of the 0x0040_0000 boundary. The alias window and the SSRAM1 window sit close enough to other edges that offsets drawn near them cross into unmapped space. Together with random configuration changes, this exercises every combination of remap and alias against every window edge.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

  // select vector positions
  localparam int NUM_SLV   = 5;
  localparam int IDX_FLASH = 0;
  localparam int IDX_SSR1  = 1;
  localparam int IDX_IRAM  = 2;
  localparam int IDX_SSR0  = 3;
  localparam int IDX_DEF   = 4;

  // decode windows
  localparam int NUM_WIN   = 6;
  localparam int W_FLASH   = 0;
  localparam int W_LOWRAM  = 1;
  localparam int W_SSR1    = 2;
  localparam int W_ALIAS   = 3;
  localparam int W_IRAM    = 4;
  localparam int W_SSR0    = 5;

  typedef struct packed {
    logic aliasOn;
    logic remapOn;
  } map_ctrl_t;

  typedef enum logic [1:0] {
    ERR_IDLE   = 2'd0,
    ERR_FIRST  = 2'd1,
    ERR_SECOND = 2'd2
  } err_state_e;

endpackage

// File: rtl/map_window.sv
module map_window #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter int                SPAN_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam int TAG_W = ADDR_W - SPAN_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SPAN_W];

  assign hit    = (addr[ADDR_W-1:SPAN_W] == BASE_TAG);
  assign offset = {{TAG_W{1'b0}}, addr[SPAN_W-1:0]};
endmodule

// File: rtl/map_addr_path.sv
module map_addr_path
  import boot_map_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE   = 'h0000_0000,
  parameter logic [ADDR_W-1:0] SSRAM1_BASE  = 'h1000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 'h1800_0000,
  parameter logic [ADDR_W-1:0] IRAM_BASE    = 'h1EFF_0000,
  parameter logic [ADDR_W-1:0] SSRAM0_BASE  = 'h2000_0000,
  parameter int                FLASH_SPAN_W = 26,
  parameter int                SSRAM_SPAN_W = 22,
  parameter int                IRAM_SPAN_W  = 16
) (
  input  logic [ADDR_W-1:0]  haddr,
  input  map_ctrl_t          ctrl,
  output logic [NUM_SLV-1:0] hsel,
  output logic [ADDR_W-1:0]  slaveAddr
);
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
    {SSRAM0_BASE, IRAM_BASE, ALIAS_BASE, SSRAM1_BASE, FLASH_BASE, FLASH_BASE};
  localparam int WIN_SPAN [NUM_WIN] =
    '{FLASH_SPAN_W, SSRAM_SPAN_W, SSRAM_SPAN_W, FLASH_SPAN_W, IRAM_SPAN_W, SSRAM_SPAN_W};

  logic [NUM_WIN-1:0] winHit;
  logic [ADDR_W-1:0]  winOff [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    map_window #(
      .ADDR_W (ADDR_W),
      .BASE   (WIN_BASE[g]),
      .SPAN_W (WIN_SPAN[g])
    ) u_win (
      .addr   (haddr),
      .hit    (winHit[g]),
      .offset (winOff[g])
    );
  end

  always_comb begin
    hsel      = '0;
    slaveAddr = haddr;
    if (winHit[W_FLASH]) begin
      if (ctrl.remapOn && winHit[W_LOWRAM]) begin
        hsel[IDX_SSR1] = 1'b1;
        slaveAddr      = winOff[W_LOWRAM];
      end else begin
        hsel[IDX_FLASH] = 1'b1;
        slaveAddr       = winOff[W_FLASH];
      end
    end else if (winHit[W_SSR1]) begin
      hsel[IDX_SSR1] = 1'b1;
      slaveAddr      = winOff[W_SSR1];
    end else if (winHit[W_ALIAS] && ctrl.aliasOn) begin
      hsel[IDX_FLASH] = 1'b1;
      slaveAddr       = winOff[W_ALIAS];
    end else if (winHit[W_IRAM]) begin
      hsel[IDX_IRAM] = 1'b1;
      slaveAddr      = winOff[W_IRAM];
    end else if (winHit[W_SSR0]) begin
      hsel[IDX_SSR0] = 1'b1;
      slaveAddr      = winOff[W_SSR0];
    end else begin
      hsel[IDX_DEF] = 1'b1;
      slaveAddr     = haddr;
    end
  end
endmodule

// File: rtl/map_cfg_ctrl.sv
module map_cfg_ctrl
  import boot_map_pkg::*;
#(
  parameter int   DATA_W      = 32,
  parameter logic ALIAS_RESET = 1'b1,
  parameter logic REMAP_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output map_ctrl_t         ctrl,
  output logic [DATA_W-1:0] cfgRdData
);
  localparam int PAD_W = DATA_W - 2;

  logic unusedWrBits;
  assign unusedWrBits = ^cfgWrData[DATA_W-1:2];

  // only the power-on reset reaches this register
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      ctrl.aliasOn <= ALIAS_RESET;
      ctrl.remapOn <= REMAP_RESET;
    end else if (cfgWrEn) begin
      ctrl.aliasOn <= cfgWrData[1];
      ctrl.remapOn <= cfgWrData[0];
    end
  end

  assign cfgRdData = {{PAD_W{1'b0}}, ctrl.aliasOn, ctrl.remapOn};
endmodule

// File: rtl/map_err_slave.sv
module map_err_slave
  import boot_map_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic selected,
  input  logic transActive,
  input  logic hreadyIn,
  output logic readyOut,
  output logic respErr
);
  err_state_e state, stateNext;
  logic       takeErr;

  assign takeErr = hreadyIn && selected && transActive;

  always_comb begin
    stateNext = state;
    unique case (state)
      ERR_IDLE:   stateNext = takeErr ? ERR_FIRST : ERR_IDLE;
      ERR_FIRST:  stateNext = ERR_SECOND;
      ERR_SECOND: stateNext = takeErr ? ERR_FIRST : ERR_IDLE;
      default:    stateNext = ERR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ERR_IDLE;
    else       state <= stateNext;
  end

  assign readyOut = (state != ERR_FIRST);
  assign respErr  = (state == ERR_FIRST) || (state == ERR_SECOND);
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
  import boot_map_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE   = 'h0000_0000,
  parameter logic [ADDR_W-1:0] SSRAM1_BASE  = 'h1000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 'h1800_0000,
  parameter logic [ADDR_W-1:0] IRAM_BASE    = 'h1EFF_0000,
  parameter logic [ADDR_W-1:0] SSRAM0_BASE  = 'h2000_0000,
  parameter int                FLASH_SPAN_W = 26,
  parameter int                SSRAM_SPAN_W = 22,
  parameter int                IRAM_SPAN_W  = 16
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hreadyIn,
  input  logic               cfgWrEn,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0]  cfgRdData,
  output logic [NUM_SLV-1:0] hsel,
  output logic [ADDR_W-1:0]  slaveAddr,
  output logic               defReadyOut,
  output logic               defResp
);
  map_ctrl_t mapCtrl;
  logic      errRstN;

  assign errRstN = porRstN & sysRstN;

  map_cfg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ctrl      (mapCtrl),
    .cfgRdData (cfgRdData)
  );

  map_addr_path #(
    .ADDR_W       (ADDR_W),
    .FLASH_BASE   (FLASH_BASE),
    .SSRAM1_BASE  (SSRAM1_BASE),
    .ALIAS_BASE   (ALIAS_BASE),
    .IRAM_BASE    (IRAM_BASE),
    .SSRAM0_BASE  (SSRAM0_BASE),
    .FLASH_SPAN_W (FLASH_SPAN_W),
    .SSRAM_SPAN_W (SSRAM_SPAN_W),
    .IRAM_SPAN_W  (IRAM_SPAN_W)
  ) u_path (
    .haddr     (haddr),
    .ctrl      (mapCtrl),
    .hsel      (hsel),
    .slaveAddr (slaveAddr)
  );

  map_err_slave u_err (
    .clk         (clk),
    .rstN        (errRstN),
    .selected    (hsel[IDX_DEF]),
    .transActive (htrans[1]),
    .hreadyIn    (hreadyIn),
    .readyOut    (defReadyOut),
    .respErr     (defResp)
  );
endmodule

// File: rtl/boot_map_checker.sv
module boot_map_checker #(
  parameter int             TAG_W     = 6,
  parameter logic [TAG_W-1:0] ALIAS_TAG = '0
) (
  input logic             clk,
  input logic             porRstN,
  input logic             sysRstN,
  input logic [TAG_W-1:0] addrTag,
  input logic             transActive,
  input logic             hreadyIn,
  input logic             cfgWrEn,
  input logic [1:0]       cfgWrLow,
  input logic [1:0]       cfgState,
  input logic [4:0]       hsel,
  input logic             defReadyOut,
  input logic             defResp
);
  // R8
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $countones(hsel) == 1);

  // R9
  cfg_write_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cfgWrEn |=> cfgState == $past(cfgWrLow));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !cfgWrEn |=> $stable(cfgState));

  // R5
  alias_off_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!cfgState[1] && addrTag == ALIAS_TAG) |-> hsel[4]);

  // R11
  err_first_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (hreadyIn && hsel[4] && transActive && defReadyOut) |=> (!defReadyOut && defResp));

  // R11
  err_second_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !defReadyOut |=> (defReadyOut && defResp));

  // R12
  okay_hold_chk: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (!(hreadyIn && hsel[4] && transActive) && defReadyOut && !defResp)
      |=> (defReadyOut && !defResp));
endmodule

bind boot_map_decoder boot_map_checker #(
  .TAG_W     (ADDR_W - FLASH_SPAN_W),
  .ALIAS_TAG (ALIAS_BASE[ADDR_W-1:FLASH_SPAN_W])
) u_chk (
  .clk         (clk),
  .porRstN     (porRstN),
  .sysRstN     (sysRstN),
  .addrTag     (haddr[ADDR_W-1:FLASH_SPAN_W]),
  .transActive (htrans[1]),
  .hreadyIn    (hreadyIn),
  .cfgWrEn     (cfgWrEn),
  .cfgWrLow    (cfgWrData[1:0]),
  .cfgState    (cfgRdData[1:0]),
  .hsel        (hsel),
  .defReadyOut (defReadyOut),
  .defResp     (defResp)
);

// File: tb/sim_boot_map_decoder.sv
`timescale 1ns/1ps
module sim_boot_map_decoder;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = '0;
  logic        hreadyIn = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [4:0]  hsel;
  logic [31:0] slaveAddr;
  logic        defReadyOut;
  logic        defResp;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic mRemap = 1'b0;
  logic mAlias = 1'b1;

  always #4 clk = ~clk;

  boot_map_decoder u0 (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .haddr(haddr),
    .htrans(htrans), .hreadyIn(hreadyIn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .hsel(hsel),
    .slaveAddr(slaveAddr), .defReadyOut(defReadyOut), .defResp(defResp)
  );

  function automatic logic [36:0] expDecode(input logic [31:0] a, input logic r, input logic al);
    logic [4:0]  s;
    logic [31:0] l;
    if (a < 32'h0400_0000) begin
      l = a;
      s = (r && a < 32'h0040_0000) ? 5'b00010 : 5'b00001;
    end else if (a >= 32'h1000_0000 && a < 32'h1040_0000) begin
      s = 5'b00010; l = a - 32'h1000_0000;
    end else if (al && a >= 32'h1800_0000 && a < 32'h1C00_0000) begin
      s = 5'b00001; l = a - 32'h1800_0000;
    end else if (a >= 32'h1EFF_0000 && a < 32'h1F00_0000) begin
      s = 5'b00100; l = a - 32'h1EFF_0000;
    end else if (a >= 32'h2000_0000 && a < 32'h2040_0000) begin
      s = 5'b01000; l = a - 32'h2000_0000;
    end else begin
      s = 5'b10000; l = a;
    end
    return {s, l};
  endfunction

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive an address at the falling edge and check the decode shortly after
  task automatic probe(input string req, input logic [31:0] a, input logic [1:0] t);
    logic [36:0] e;
    @(negedge clk);
    haddr = a; htrans = t;
    #1;
    e = expDecode(a, mRemap, mAlias);
    checkVal(req, {27'd0, hsel, slaveAddr}, {27'd0, e});
  endtask

  task automatic cfgWrite(input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mAlias = d[1]; mRemap = d[0];
  endtask

  task automatic checkResp(input string req, input logic rdy, input logic rsp);
    checkVal(req, {62'd0, defReadyOut, defResp}, {62'd0, rdy, rsp});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    porRstN = 1'b1; sysRstN = 1'b1;
    @(negedge clk);

    // R1 power-on state
    checkVal("R1 cfg", {32'd0, cfgRdData}, 64'h2);
    probe("R1 zero", 32'h0000_0000, 2'd0);
    probe("R1 alias", 32'h1800_0010, 2'd0);
    checkResp("R12 reset okay", 1'b1, 1'b0);

    // R2 flash direct
    probe("R2 low", 32'h0000_1000, 2'd2);
    probe("R2 top", 32'h03FF_FFFC, 2'd2);

    // R3 remap
    cfgWrite(32'h3);
    checkVal("R9 readback", {32'd0, cfgRdData}, 64'h3);
    probe("R3 ram low", 32'h0000_1000, 2'd2);
    probe("R3 ram edge", 32'h003F_FFFC, 2'd2);
    probe("R3 flash above", 32'h0040_0000, 2'd2);
    probe("R4 ssram1", 32'h1000_0040, 2'd2);
    probe("R4 past end", 32'h1040_0000, 2'd0);

    // R5 alias off
    cfgWrite(32'h1);
    probe("R5 alias off", 32'h1800_0000, 2'd0);
    probe("R5 alias off top", 32'h1BFF_FFFC, 2'd0);
    probe("R6 iram", 32'h1EFF_8004, 2'd0);
    probe("R6 ssram0", 32'h2012_3450, 2'd0);
    probe("R7 unmapped", 32'hDFFF_0028, 2'd0);

    // R9 upper write bits ignored
    cfgWrite(32'hFFFF_FFFC);
    checkVal("R9 upper ignored", {32'd0, cfgRdData}, 64'h0);

    // R10 soft reset keeps configuration
    cfgWrite(32'h1);
    @(negedge clk); sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R10 during soft reset", {32'd0, cfgRdData}, 64'h1);
    sysRstN = 1'b1;
    @(negedge clk);
    checkVal("R10 after soft reset", {32'd0, cfgRdData}, 64'h1);
    porRstN = 1'b0;
    @(negedge clk);
    porRstN = 1'b1; mAlias = 1'b1; mRemap = 1'b0;
    checkVal("R10 por clears", {32'd0, cfgRdData}, 64'h2);

    // R11 error response
    probe("R7 default sel", 32'hDFFF_0000, 2'd2);
    checkResp("R12 before edge", 1'b1, 1'b0);
    @(negedge clk);
    checkResp("R11 first", 1'b0, 1'b1);
    htrans = 2'd0; hreadyIn = 1'b0;
    @(negedge clk);
    checkResp("R11 second", 1'b1, 1'b1);
    hreadyIn = 1'b1;
    @(negedge clk);
    checkResp("R12 back okay", 1'b1, 1'b0);
    // R11 SEQ starts error too
    htrans = 2'd3;
    @(negedge clk);
    checkResp("R11 seq first", 1'b0, 1'b1);
    htrans = 2'd0;
    @(negedge clk);
    checkResp("R11 seq second", 1'b1, 1'b1);
    // R12 BUSY to default
    htrans = 2'd1;
    @(negedge clk);
    checkResp("R12 busy", 1'b1, 1'b0);
    // R12 NONSEQ to mapped slave
    haddr = 32'h2000_0000; htrans = 2'd2;
    @(negedge clk);
    checkResp("R12 mapped", 1'b1, 1'b0);
    // R12 waited transfer
    haddr = 32'hDFFF_0000; hreadyIn = 1'b0;
    @(negedge clk);
    checkResp("R12 not ready", 1'b1, 1'b0);
    // R13 soft reset aborts error
    hreadyIn = 1'b1;
    @(negedge clk);
    checkResp("R13 in error", 1'b0, 1'b1);
    htrans = 2'd0; sysRstN = 1'b0;
    #1;
    checkResp("R13 reset", 1'b1, 1'b0);
    @(negedge clk); sysRstN = 1'b1;

    // R8 random decode under random configuration
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      if (i % 60 == 0) cfgWrite({30'd0, 2'($urandom)});
      case ($urandom % 9)
        0: a = $urandom & 32'h03FF_FFFF;
        1: a = 32'h0040_0000 - 32'd8 + ($urandom % 16);
        2: a = 32'h1000_0000 + ($urandom & 32'h007F_FFFF);
        3: a = 32'h1800_0000 + ($urandom & 32'h07FF_FFFF);
        4: a = 32'h1EFE_0000 + ($urandom & 32'h0003_FFFF);
        5: a = 32'h2000_0000 + ($urandom & 32'h007F_FFFF);
        6: a = 32'h03FF_FFF0 + ($urandom % 32);
        7: a = 32'h1BFF_FFF0 + ($urandom % 32);
        default: a = $urandom;
      endcase
      probe("R8 random decode", a, 2'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule